// File: doc/BRIEF.md
# Converter Conversion Control Sequencer

This block is the digital control core of a successive-approximation converter. An active-low chip select and a read/convert strobe are the only controls. A conversion request exists at any clock edge where both are low. Once a conversion is accepted, a busy flag drops for a fixed number of clock cycles. That fixed count stands in for the analog conversion. The sample value comes in on a stimulus port and is held when the conversion starts. When the timer expires, the held value is latched into the result register.

Reading uses the same two pins. With chip select low and read/convert high, the parallel bus is driven. At all other times it is high-impedance. The bus always shows the most recently completed result. A read during conversion n therefore returns result n-1, and a read after completion returns result n. A format pin selects straight binary or two's complement at the bus.

The block counts the idle cycles since the last completion. A conversion that starts before the minimum acquisition time has passed is marked invalid. The case that triggers this is holding both controls low through the end of a conversion. The next conversion then starts at once with no fresh acquisition, and a status bit reports it.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, busy_o is 1, invalid_o is 0 and the result register holds 0, so a read returns 0 in straight-binary format.
- R2: If cs_ni and rc_i are both 0 at a rising edge while busy_o is 1, busy_o is 0 from that edge onward.
- R3: busy_o stays 0 for exactly CONV_CYC clock cycles per conversion; start requests seen while busy_o is 0 are ignored and do not change that length.
- R4: sample_i is captured at the edge that starts a conversion. Changes to sample_i during the conversion do not alter the result. The result register updates only at the edge where busy_o returns to 1.
- R5: A start is acquired only if busy_o has been 1 for at least ACQ_CYC cycles at the start edge. After reset the count begins at zero; after a completion it begins at one.
- R6: invalid_o is set at the edge that starts an unacquired conversion. It is cleared at the completion of an acquired conversion, and otherwise holds. Holding both controls low through a completion restarts at once and sets invalid_o.
- R7: bus_oe_o is 1 exactly when cs_ni is 0 and rc_i is 1. Otherwise bus_o is high-impedance; chip select high always disables the bus.
- R8: When enabled, the bus shows the latest completed result: during conversion n it shows result n-1, and after completion it shows result n.
- R9: fmt_sb_i = 1 drives the stored code unchanged (straight binary). fmt_sb_i = 0 inverts the MSB (two's complement), so 8000h reads as 0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read (1) / convert (0) strobe |
| fmt_sb_i | input | 1 | Output format: 1 straight binary, 0 two's complement |
| sample_i | input | DATA_W | Sample value standing in for the analog input |
| busy_o | output | 1 | 1 when idle, 0 while converting |
| invalid_o | output | 1 | Last started conversion lacked acquisition time |
| bus_oe_o | output | 1 | Parallel bus enable |
| bus_o | output | DATA_W | Tri-state parallel data bus |

## Verification
The critical coincidence is the completion edge. On that edge the result is latched, busy returns high, the invalid flag may clear and the acquisition count restarts. If the controls are still low, a new start follows on the very next edge. The bench holds both controls low across completions and also reads the bus on the cycles around completion. A per-cycle reference model computed from the requirements then judges busy, invalid, bus enable and bus value on every cycle, so it shows whether the bus moves from result n-1 to result n on the right edge and whether the restart is flagged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {
    PH_TRACK = 1'b0,
    PH_CONV  = 1'b1
  } phase_e;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC = 12
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   done_o
);
  localparam int CW = $clog2(CONV_CYC + 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_TRACK;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_TRACK: if (start_i) begin
          phase_q <= PH_CONV;
          cnt_q   <= CW'(CONV_CYC - 1);
        end
        PH_CONV: begin
          if (cnt_q == '0) phase_q <= PH_TRACK;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_TRACK;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = (phase_q == PH_CONV) && (cnt_q == '0);
endmodule

// File: rtl/adc_acq_tracker.sv
module adc_acq_tracker #(
  parameter int ACQ_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tracking_i,
  input  logic start_i,
  input  logic done_i,
  output logic acq_ok_o
);
  localparam int AW = $clog2(ACQ_CYC + 1);
  localparam logic [AW-1:0] ACQ_MAX = AW'(ACQ_CYC);

  logic [AW-1:0] acq_q;

  // counts idle cycles since completion, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     acq_q <= '0;
    else if (done_i)                                 acq_q <= AW'(1);
    else if (tracking_i && !start_i && acq_q != ACQ_MAX) acq_q <= acq_q + 1'b1;
  end

  assign acq_ok_o = (acq_q >= ACQ_MAX);
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              acq_ok_i,
  input  logic              fmt_sb_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] code_o,
  output logic              invalid_o
);
  logic [DATA_W-1:0] held_q, res_q;
  logic              cur_bad_q, invalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q    <= '0;
      res_q     <= '0;
      cur_bad_q <= 1'b0;
      invalid_q <= 1'b0;
    end else begin
      if (start_i) begin
        held_q    <= sample_i;
        cur_bad_q <= !acq_ok_i;
        if (!acq_ok_i) invalid_q <= 1'b1;
      end
      if (done_i) begin
        res_q <= held_q;
        if (!cur_bad_q) invalid_q <= 1'b0;
      end
    end
  end

  assign res_o     = res_q;
  assign code_o    = fmt_sb_i ? res_q : {~res_q[DATA_W-1], res_q[DATA_W-2:0]};
  assign invalid_o = invalid_q;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 12,
  parameter int ACQ_CYC  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rc_i,
  input  logic              fmt_sb_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic              invalid_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] bus_o
);
  phase_e            phase;
  logic              done, acq_ok, start_go;
  logic [DATA_W-1:0] res_q, code;

  // both enables low = convert request; level sensitive
  assign start_go = !cs_ni && !rc_i && (phase == PH_TRACK);

  adc_conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_go),
    .phase_o (phase),
    .done_o  (done)
  );

  adc_acq_tracker #(.ACQ_CYC(ACQ_CYC)) u_acq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tracking_i (phase == PH_TRACK),
    .start_i    (start_go),
    .done_i     (done),
    .acq_ok_o   (acq_ok)
  );

  adc_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_go),
    .done_i    (done),
    .acq_ok_i  (acq_ok),
    .fmt_sb_i  (fmt_sb_i),
    .sample_i  (sample_i),
    .res_o     (res_q),
    .code_o    (code),
    .invalid_o (invalid_o)
  );

  assign busy_o   = (phase == PH_TRACK);
  assign bus_oe_o = !cs_ni && rc_i;
  assign bus_o    = bus_oe_o ? code : 'z;
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rc_i,
  input logic              busy_o,
  input logic              invalid_o,
  input logic              bus_oe_o,
  input logic [DATA_W-1:0] res_i
);
  localparam int RW = $clog2(CONV_CYC + 1);
  logic [RW-1:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_run_q <= '0;
    else if (!busy_o) low_run_q <= low_run_q + 1'b1;
    else             low_run_q <= '0;
  end

  AST_START_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !cs_ni && !rc_i |=> !busy_o); // R2
  AST_CONV_LEN_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> low_run_q == RW'(CONV_CYC)); // R3
  AST_CONV_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> low_run_q < RW'(CONV_CYC)); // R3
  AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_i) |-> $rose(busy_o)); // R4
  AST_INVALID_SET_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(invalid_o) |-> $fell(busy_o)); // R6
  AST_INVALID_CLR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(invalid_o) |-> $rose(busy_o)); // R6
  AST_CS_HIGH_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !bus_oe_o); // R7
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rc_i      (rc_i),
  .busy_o    (busy_o),
  .invalid_o (invalid_o),
  .bus_oe_o  (bus_oe_o),
  .res_i     (res_q)
);

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb;
  localparam int W = 16, CONV = 12, ACQ = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_n = 1'b1, rc = 1'b1, fmt = 1'b1;
  logic [W-1:0] smp = '0;
  logic busy, inv, oe;
  logic [W-1:0] bus;

  adc_conv_ctrl #(.DATA_W(W), .CONV_CYC(CONV), .ACQ_CYC(ACQ)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .rc_i(rc), .fmt_sb_i(fmt),
    .sample_i(smp), .busy_o(busy), .invalid_o(inv), .bus_oe_o(oe), .bus_o(bus)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // reference model, stepped on each rising edge
  bit m_busy = 1, m_inv = 0, m_bad = 0;
  int m_left = 0, m_idle = 0;
  logic [W-1:0] m_held = '0, m_res = '0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_busy = 1; m_inv = 0; m_bad = 0; m_left = 0; m_idle = 0; m_held = '0; m_res = '0;
    end else if (m_busy) begin
      if (!cs_n && !rc) begin
        m_busy = 0; m_left = CONV; m_bad = (m_idle < ACQ);
        if (m_bad) m_inv = 1;
        m_held = smp;
      end else if (m_idle < ACQ) m_idle++;
    end else begin
      m_left--;
      if (m_left == 0) begin
        m_busy = 1; m_res = m_held; m_idle = 1;
        if (!m_bad) m_inv = 0;
      end
    end
  end

  function automatic logic [W-1:0] exp_code(logic [W-1:0] r, logic f);
    return f ? r : {~r[W-1], r[W-2:0]};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2", "busy", 32'(busy), 32'(m_busy));
    chk("R6", "invalid", 32'(inv), 32'(m_inv));
    chk("R7", "bus enable", 32'(oe), 32'(!cs_n && rc));
    if (!cs_n && rc) chk("R8", "bus value", 32'(bus), 32'(exp_code(m_res, fmt)));
  endtask

  task automatic step(logic c, logic r, logic f, logic [W-1:0] s);
    @(negedge clk); #1;
    cmp_all();
    cs_n = c; rc = r; fmt = f; smp = s;
  endtask

  // every busy-low run must last CONV cycles
  int run = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!busy) run++;
      else if (run != 0) begin
        chk("R3", "busy low length", 32'(run), 32'(CONV));
        run = 0;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    step(1, 1, 1, '0);
    chk("R1", "busy after reset", 32'(busy), 32'd1);
    chk("R1", "invalid after reset", 32'(inv), 32'd0);
    step(0, 1, 1, '0); #1;
    chk("R1", "result after reset", 32'(bus), 32'd0);

    // clean conversion of midscale, with ignored starts and sample changes
    repeat (ACQ + 2) step(1, 1, 1, 16'h1234);
    step(0, 0, 1, 16'h8000);
    step(1, 1, 1, 16'h5555);
    chk("R2", "busy after start", 32'(busy), 32'd0);
    chk("R5", "acquired start not invalid", 32'(inv), 32'd0);
    repeat (4) step(0, 0, 1, 16'hAAAA);
    step(0, 1, 1, 16'h7777); #1;
    chk("R8", "previous result during conversion", 32'(bus), 32'd0);
    repeat (CONV) step(1, 1, 1, '0);
    step(0, 1, 1, '0); #1;
    chk("R9", "straight binary midscale", 32'(bus), 32'h8000);
    chk("R4", "held sample latched", 32'(bus), 32'h8000);
    step(0, 1, 0, '0); #1;
    chk("R9", "twos complement midscale", 32'(bus), 32'h0000);

    // immediate restart while both controls stay low
    repeat (ACQ + 2) step(1, 1, 1, '0);
    step(0, 0, 1, 16'h1357);
    repeat (CONV + 2) step(0, 0, 1, 16'h2468);
    chk("R6", "restart flagged invalid", 32'(inv), 32'd1);
    chk("R5", "restart in progress", 32'(busy), 32'd0);
    repeat (CONV) step(1, 1, 1, '0);
    step(0, 1, 1, '0); #1;
    chk("R6", "invalid held after bad completion", 32'(inv), 32'd1);
    chk("R4", "restart result is sample at its start", 32'(bus), 32'h2468);
    repeat (ACQ + 2) step(1, 1, 1, '0);
    step(0, 0, 1, 16'h0F0F);
    repeat (CONV + 1) step(1, 1, 1, '0);
    chk("R6", "invalid cleared by good completion", 32'(inv), 32'd0);

    step(1, 0, 1, '0); #1;
    chk("R7", "cs high with rc low", 32'(oe), 32'd0);
    step(1, 1, 0, '0); #1;
    chk("R7", "cs high with rc high", 32'(oe), 32'd0);

    // constrained random control patterns
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 8;
      int len = 1 + $urandom % 15;
      logic f = 1'($urandom);
      logic c, r;
      if (sel < 3)      begin c = 1; r = 1; end
      else if (sel < 5) begin c = 0; r = 0; end
      else if (sel < 7) begin c = 0; r = 1; end
      else              begin c = 1; r = 0; end
      for (int k = 0; k < len; k++) step(c, r, f, W'($urandom));
    end

    repeat (CONV + ACQ) step(1, 1, 1, '0);
    summary();
    $finish;
  end
endmodule